// File: doc/BRIEF.md
# Region-Based Memory Protection Checker

This block decides whether a bus master may make a particular access. Each access arrives as a master number, a byte address and a kind: read, write or instruction fetch. The block compares the address with sixteen programmable regions at once and gives an allow or deny answer in the same cycle. Software sets up each region through a small write-only register port. A region holds an inclusive start address, an inclusive end address, a valid bit, and separate read, write and execute rights for each of three masters.

When the block refuses an access, it records the details of the first refusal in a set of error registers and raises a sticky flag. The flag stays set until software clears it. Later refusals do not overwrite the recorded details while the flag is set. The block is intended to sit beside a crossbar or bus bridge. The bridge uses `acc_allow` to pass or block the access. An error handler reads the captured fields and then pulses `err_clr`.

Top module: `mpu_checker`

## Requirements
- R1: After a synchronous active-low reset, every region is invalid, so every access is denied, and `err_flag` is 0.
- R2: All regions are evaluated in parallel. An access is allowed when at least one valid region covers the address and grants the requested right to the requesting master. Rights from overlapping regions combine as a logical OR.
- R3: Region bounds use 32-byte blocks. Address bits [4:0] are ignored in the access address and in both bounds. The start block and the end block are both inclusive.
- R4: The attribute word (`cfg_sel`=2) has the valid bit at bit 0. For master m, bit 1+3m is read, bit 2+3m is write and bit 3+3m is execute. `cfg_sel`=0 writes the start address and `cfg_sel`=1 writes the end address. `cfg_sel`=3 writes nothing.
- R5: An access that falls in no valid region is denied. Access kind encoding: 0 read, 1 write, 2 execute. Kind 3 is always denied.
- R6: A region whose end block is below its start block matches no address.
- R7: `acc_allow` is combinational from the access inputs in the same cycle, and it is 0 whenever `acc_valid` is 0.
- R8: A denied valid access while `err_flag` is 0 sets `err_flag` at the next clock edge. The same edge loads `err_addr`, `err_master` and `err_kind` with that access's full address, master and kind.
- R9: While `err_flag` is set and `err_clr` is low, further denied accesses leave `err_flag`, `err_addr`, `err_master` and `err_kind` unchanged.
- R10: `err_clr` clears `err_flag` at the next edge. If a denied access occurs in the same cycle as `err_clr`, that access is captured and the flag stays set.
- R11: A region register write takes effect at the next clock edge. An access in the same cycle as the write is judged on the region's old contents.
- R12: Master numbers of 3 or more have no rights and are always denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Region register write strobe |
| cfg_region | input | 4 | Region index for the write |
| cfg_sel | input | 2 | 0 start, 1 end, 2 attributes, 3 none |
| cfg_wdata | input | 32 | Write data |
| acc_valid | input | 1 | Access present this cycle |
| acc_master | input | 2 | Requesting master number |
| acc_kind | input | 2 | 0 read, 1 write, 2 execute |
| acc_addr | input | 32 | Byte address of the access |
| acc_allow | output | 1 | Access permitted (same cycle) |
| err_clr | input | 1 | Clears the sticky error flag |
| err_flag | output | 1 | Sticky error flag |
| err_addr | output | 32 | Address of the captured access |
| err_master | output | 2 | Master of the captured access |
| err_kind | output | 2 | Kind of the captured access |

## Verification
Two pairs of events can happen in the same cycle. The first pair is a region write and an access to that region. The bench drives both in one cycle and expects the old verdict in that cycle and the new verdict in the following cycle. The second pair is `err_clr` and a fresh denial. The bench pulses the clear alongside a refused access and expects the flag to stay set with the new address, master and kind captured. A behavioural reference model in the bench is compared with `acc_allow` and the error outputs on every cycle.

// File: rtl/mpu_pkg.sv
// Shared encodings for the memory protection checker.
// Assumes the access-kind code doubles as the right offset inside a master's
// three-bit permission group.
package mpu_pkg;
    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_EXEC  = 2'd2,
        KIND_NONE  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        SEL_START = 2'd0,
        SEL_END   = 2'd1,
        SEL_ATTR  = 2'd2,
        SEL_NONE  = 2'd3
    } cfg_sel_e;

    localparam int RIGHTS_PER_MASTER = 3;
endpackage

// File: rtl/mpu_region.sv
// One protection region: holds bounds and rights, and reports whether the
// current access falls inside it and whether it grants the requested right.
// Assumes 1 + 3*NUM_MASTERS <= ADDR_W so the attribute word fits the bus.
module mpu_region
    import mpu_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int GRAN_BITS   = 5,
    parameter int NUM_MASTERS = 3,
    parameter int MID_W       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [MID_W-1:0]  acc_master,
    input  logic [1:0]        acc_kind,
    output logic              hit,
    output logic              grant
);
    localparam int BLK_W  = ADDR_W - GRAN_BITS;
    localparam int PERM_W = RIGHTS_PER_MASTER * NUM_MASTERS;

    logic [BLK_W-1:0]  start_blk;
    logic [BLK_W-1:0]  end_blk;
    logic              valid_q;
    logic [PERM_W-1:0] perm_q;
    logic [BLK_W-1:0]  acc_blk;
    logic              perm_bit;

    // Store region fields on a register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_blk <= '0;
            end_blk   <= '0;
            valid_q   <= 1'b0;
            perm_q    <= '0;
        end else if (wr_en) begin
            case (cfg_sel_e'(wr_sel))
                SEL_START: start_blk <= wr_data[ADDR_W-1:GRAN_BITS];
                SEL_END:   end_blk   <= wr_data[ADDR_W-1:GRAN_BITS];
                SEL_ATTR: begin
                    valid_q <= wr_data[0];
                    perm_q  <= wr_data[PERM_W:1];
                end
                default: ;
            endcase
        end
    end

    assign acc_blk = acc_addr[ADDR_W-1:GRAN_BITS];
    // Inclusive block-range match; an inverted range can never satisfy both sides.
    assign hit = valid_q && (acc_blk >= start_blk) && (acc_blk <= end_blk);

    // Select the requested right of the requesting master.
    always_comb begin
        perm_bit = 1'b0;
        for (int m = 0; m < NUM_MASTERS; m++) begin
            if (acc_master == MID_W'(m) && acc_kind != KIND_NONE)
                perm_bit = perm_q[RIGHTS_PER_MASTER * m + int'(acc_kind)];
        end
    end

    assign grant = hit && perm_bit;

    // R6
    inverted_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_blk > end_blk) |-> !hit);
endmodule

// File: rtl/mpu_err_capture.sv
// Sticky error capture: records the first denied access until cleared.
// Assumes viol is already qualified by the access valid strobe.
module mpu_err_capture #(
    parameter int ADDR_W = 32,
    parameter int MID_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              viol,
    input  logic              clr,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [MID_W-1:0]  acc_master,
    input  logic [1:0]        acc_kind,
    output logic              flag,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [MID_W-1:0]  cap_master,
    output logic [1:0]        cap_kind
);
    // Capture on a fresh violation (or one coinciding with a clear), else clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag       <= 1'b0;
            cap_addr   <= '0;
            cap_master <= '0;
            cap_kind   <= '0;
        end else if (viol && (!flag || clr)) begin
            flag       <= 1'b1;
            cap_addr   <= acc_addr;
            cap_master <= acc_master;
            cap_kind   <= acc_kind;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

    // R8
    first_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (viol && !flag) |=> (flag && cap_addr == $past(acc_addr)));
    // R9
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> (flag && $stable(cap_addr) && $stable(cap_master) && $stable(cap_kind)));
    // R10
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !viol) |=> !flag);
endmodule

// File: rtl/mpu_checker.sv
// Top of the memory protection checker: a bank of regions compared in
// parallel, an OR of their grants, and sticky capture of the first denial.
// Assumes the caller holds access inputs stable for the cycle they are judged.
module mpu_checker
    import mpu_pkg::*;
#(
    parameter int NUM_REGIONS = 16,
    parameter int NUM_MASTERS = 3,
    parameter int ADDR_W      = 32,
    parameter int GRAN_BITS   = 5,
    parameter int MID_W       = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [$clog2(NUM_REGIONS)-1:0] cfg_region,
    input  logic [1:0]                     cfg_sel,
    input  logic [ADDR_W-1:0]              cfg_wdata,
    input  logic                           acc_valid,
    input  logic [MID_W-1:0]               acc_master,
    input  logic [1:0]                     acc_kind,
    input  logic [ADDR_W-1:0]              acc_addr,
    output logic                           acc_allow,
    input  logic                           err_clr,
    output logic                           err_flag,
    output logic [ADDR_W-1:0]              err_addr,
    output logic [MID_W-1:0]               err_master,
    output logic [1:0]                     err_kind
);
    localparam int RIDX_W = $clog2(NUM_REGIONS);

    logic [NUM_REGIONS-1:0] hit_vec;
    logic [NUM_REGIONS-1:0] grant_vec;
    logic                   viol;

    // One region instance per index, each seeing its own write strobe.
    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
        mpu_region #(
            .ADDR_W      (ADDR_W),
            .GRAN_BITS   (GRAN_BITS),
            .NUM_MASTERS (NUM_MASTERS),
            .MID_W       (MID_W)
        ) i_region (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (cfg_we && cfg_region == RIDX_W'(r)),
            .wr_sel     (cfg_sel),
            .wr_data    (cfg_wdata),
            .acc_addr   (acc_addr),
            .acc_master (acc_master),
            .acc_kind   (acc_kind),
            .hit        (hit_vec[r]),
            .grant      (grant_vec[r])
        );
    end

    // Same-cycle decision: any granting region allows the access.
    assign acc_allow = acc_valid && (|grant_vec);
    assign viol      = acc_valid && !acc_allow;

    mpu_err_capture #(
        .ADDR_W (ADDR_W),
        .MID_W  (MID_W)
    ) i_err (
        .clk        (clk),
        .rst_n      (rst_n),
        .viol       (viol),
        .clr        (err_clr),
        .acc_addr   (acc_addr),
        .acc_master (acc_master),
        .acc_kind   (acc_kind),
        .flag       (err_flag),
        .cap_addr   (err_addr),
        .cap_master (err_master),
        .cap_kind   (err_kind)
    );

    // R5
    no_region_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vec == '0) |-> !acc_allow);
    // R12
    bad_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(acc_master) >= NUM_MASTERS) |-> !acc_allow);
    // R7
    idle_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !acc_allow);
endmodule

// File: tb/test_mpu_checker.sv
module test_mpu_checker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_region = '0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_master = '0;
    logic [1:0]  acc_kind = '0;
    logic [31:0] acc_addr = '0;
    logic        acc_allow;
    logic        err_clr = 1'b0;
    logic        err_flag;
    logic [31:0] err_addr;
    logic [1:0]  err_master;
    logic [1:0]  err_kind;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // Reference model state.
    logic [31:0] m_start [16];
    logic [31:0] m_end   [16];
    logic [31:0] m_attr  [16];
    logic        m_flag;
    logic [31:0] m_eaddr;
    logic [1:0]  m_emaster;
    logic [1:0]  m_ekind;

    always #2 clk = ~clk;

    mpu_checker i_mpu_checker (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_region(cfg_region),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .acc_valid(acc_valid),
        .acc_master(acc_master), .acc_kind(acc_kind), .acc_addr(acc_addr),
        .acc_allow(acc_allow), .err_clr(err_clr), .err_flag(err_flag),
        .err_addr(err_addr), .err_master(err_master), .err_kind(err_kind)
    );

    function automatic bit model_allow(bit v, int m, int k, logic [31:0] a);
        bit ok = 0;
        if (!v || m >= 3 || k >= 3) return 0;
        for (int r = 0; r < 16; r++) begin
            if (m_attr[r][0] && (a >> 5) >= (m_start[r] >> 5) && (a >> 5) <= (m_end[r] >> 5)
                && m_attr[r][1 + 3*m + k])
                ok = 1;
        end
        return ok;
    endfunction

    // Model update at each edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < 16; r++) begin
                m_start[r] <= 0; m_end[r] <= 0; m_attr[r] <= 0;
            end
            m_flag <= 0; m_eaddr <= 0; m_emaster <= 0; m_ekind <= 0;
        end else begin
            if (cfg_we) begin
                if (cfg_sel == 0) m_start[cfg_region] <= cfg_wdata;
                else if (cfg_sel == 1) m_end[cfg_region] <= cfg_wdata;
                else if (cfg_sel == 2) m_attr[cfg_region] <= cfg_wdata;
            end
            if (acc_valid && !model_allow(acc_valid, acc_master, acc_kind, acc_addr)
                && (!m_flag || err_clr)) begin
                m_flag <= 1; m_eaddr <= acc_addr; m_emaster <= acc_master; m_ekind <= acc_kind;
            end else if (err_clr) m_flag <= 0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Apply one cycle of stimulus, then compare against the model before the edge.
    task automatic drive(input bit we, input int rg, input int sel, input logic [31:0] d,
                         input bit av, input int m, input int k, input logic [31:0] a,
                         input bit clr, input string tag);
        @(negedge clk);
        cfg_we = we; cfg_region = 4'(rg); cfg_sel = 2'(sel); cfg_wdata = d;
        acc_valid = av; acc_master = 2'(m); acc_kind = 2'(k); acc_addr = a; err_clr = clr;
        #1;
        if (rst_n) begin
            chk({tag, " R7 model allow"}, 32'(acc_allow), 32'(model_allow(av, m, k, a)));
            chk({tag, " R8 model flag"}, 32'(err_flag), 32'(m_flag));
            if (m_flag) chk({tag, " R9 model addr"}, err_addr, m_eaddr);
        end
    endtask

    task automatic cfg(input int rg, input int sel, input logic [31:0] d);
        drive(1, rg, sel, d, 0, 0, 0, 0, 0, "cfg");
    endtask

    task automatic acc(input int m, input int k, input logic [31:0] a, input string tag);
        drive(0, 0, 0, 0, 1, m, k, a, 0, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1: reset state
        acc(0, 0, 32'h1000, "R1");
        chk("R1 deny after reset", 32'(acc_allow), 0);
        chk("R1 flag clear", 32'(err_flag), 0);
        drive(0, 0, 0, 0, 0, 0, 0, 0, 1, "clr");

        // Region 0: 0x1000..0x1FFF, master0 read+exec, master1 read+write
        cfg(0, 0, 32'h0000_1000);
        cfg(0, 1, 32'h0000_1FE7);
        cfg(0, 2, 32'h0000_003B);
        cfg(0, 3, 32'hFFFF_FFFF); // R4: selector 3 writes nothing
        acc(0, 0, 32'h1000, "R2");
        chk("R2 m0 read in region", 32'(acc_allow), 1);
        acc(0, 1, 32'h1004, "R4");
        chk("R4 m0 write denied", 32'(acc_allow), 0);
        acc(1, 1, 32'h1800, "R4");
        chk("R4 m1 write allowed", 32'(acc_allow), 1);
        acc(2, 0, 32'h1800, "R4");
        chk("R4 m2 no rights", 32'(acc_allow), 0);
        acc(0, 2, 32'h1FFF, "R3");
        chk("R3 end block inclusive", 32'(acc_allow), 1);
        acc(0, 0, 32'h2000, "R3");
        chk("R3 past end", 32'(acc_allow), 0);
        acc(0, 0, 32'h0FFF, "R5");
        chk("R5 below start no region", 32'(acc_allow), 0);
        acc(0, 3, 32'h1000, "R5");
        chk("R5 kind 3 denied", 32'(acc_allow), 0);
        acc(3, 0, 32'h1000, "R12");
        chk("R12 master 3 denied", 32'(acc_allow), 0);

        // Region 1 overlaps region 0's last block, master0 write only
        cfg(1, 0, 32'h0000_1FE0);
        cfg(1, 1, 32'h0000_2FFF);
        cfg(1, 2, 32'h0000_0005);
        acc(0, 1, 32'h1FF0, "R2");
        chk("R2 OR of overlapping write", 32'(acc_allow), 1);
        acc(0, 0, 32'h1FF0, "R2");
        chk("R2 OR of overlapping read", 32'(acc_allow), 1);
        acc(0, 0, 32'h2100, "R2");
        chk("R2 region1 no read", 32'(acc_allow), 0);

        // Region 15 inverted, all rights
        cfg(15, 0, 32'h0000_1033);
        cfg(15, 1, 32'h0000_1010);
        cfg(15, 2, 32'h0000_03FF);
        acc(2, 0, 32'h1018, "R6");
        chk("R6 inverted range matches nothing", 32'(acc_allow), 0);
        acc(2, 0, 32'h1020, "R6");
        chk("R6 inverted range start block", 32'(acc_allow), 0);

        // Error capture sequence
        drive(0, 0, 0, 0, 0, 0, 0, 0, 1, "clr");
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, "idle");
        chk("R10 flag cleared", 32'(err_flag), 0);
        acc(1, 2, 32'h0000_5004, "R8");
        acc(2, 1, 32'h0000_6008, "R9");
        chk("R8 flag set", 32'(err_flag), 1);
        chk("R8 addr captured", err_addr, 32'h0000_5004);
        chk("R8 master captured", 32'(err_master), 1);
        chk("R8 kind captured", 32'(err_kind), 2);
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, "idle");
        chk("R9 addr held", err_addr, 32'h0000_5004);
        chk("R9 master held", 32'(err_master), 1);
        drive(0, 0, 0, 0, 1, 0, 1, 32'h0000_7010, 1, "R10");
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, "idle");
        chk("R10 clear with violation keeps flag", 32'(err_flag), 1);
        chk("R10 new addr captured", err_addr, 32'h0000_7010);
        chk("R10 new kind captured", 32'(err_kind), 1);

        // R11: write and access in the same cycle
        cfg(2, 0, 32'h0000_8000);
        cfg(2, 1, 32'h0000_8000);
        drive(1, 2, 2, 32'h0000_0003, 1, 0, 0, 32'h0000_801F, 0, "R11");
        chk("R11 same-cycle write uses old", 32'(acc_allow), 0);
        acc(0, 0, 32'h0000_801F, "R11");
        chk("R11 write visible next cycle", 32'(acc_allow), 1);
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
        chk("R7 idle gives no allow", 32'(acc_allow), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule